// File: doc/BRIEF.md
# I2C Byte FIFO Pair with Threshold Events

This block sits between an I2C shift engine and the register and DMA side of a controller. It keeps one byte queue for received data and one for data waiting to be sent. The shift engine pushes received bytes and pops bytes to transmit. Software or a DMA engine reads and writes the other end. A single configuration word sets a fill threshold for each direction and can flush either queue.

The block turns queue state into event bits. A ready event fires when enough bytes, or enough free space, are present to serve a burst of threshold+1. A drain event fires when the remaining transfer length is too short to reach that threshold, so the tail of a transfer still gets serviced. Receive overrun and transmit underflow are sticky error bits. Every status bit is cleared by writing one to it. An enable mask selects which bits drive the single interrupt line.

Status bits change on the clock edge after the condition or event that sets them is visible at the registers or inputs.

Top module: `i2c_fifo_events`

## Requirements
- R1: The receive queue and the transmit queue each hold DEPTH bytes (default 32) and return bytes in the order they were written. A transmit write while the queue holds DEPTH bytes is dropped.
- R2: The configuration word has these fields:
  - bit 14 flushes the receive queue;
  - bits 13:8 are the receive threshold;
  - bit 6 flushes the transmit queue;
  - bits 5:0 are the transmit threshold.
  
  `cfg_rdata` returns the last written word with bits 14 and 6 reading zero.
- R3: `size_code` encodes the queue depth as 8 << code. The default depth of 32 gives code 2.
- R4: Status bit 0 (receive ready) is set when the receive level is at least the receive threshold plus one.
- R5: Status bit 1 (transmit ready) is set when the free transmit space (DEPTH minus level) is at least the transmit threshold plus one.
- R6: Drain events:
  - Status bit 2 (receive drain) is set when the receive level is nonzero and `xfer_left` is no greater than the receive threshold.
  - Status bit 3 (transmit drain) is set when `xfer_left` is nonzero, no greater than the transmit threshold, and larger than the transmit level.
- R7: Status bit 4 (receive overrun) is set when a receive push arrives while the receive queue is full with no read in the same cycle. That byte is dropped. A push and a read together on a full queue are both accepted.
- R8: Status bit 5 (transmit underflow) is set when the shift engine pops an empty transmit queue. The transmit level stays zero.
- R9: A `sts_clr` write clears the status bits whose `sts_wdata` bit is one. Otherwise a status bit stays set. A bit whose set condition holds in the same cycle as the clear stays, or becomes, set.
- R10: `irq` is high exactly when some status bit and its enable bit (written through `ien_wr`) are both one.
- R11: While `rst_n` is low at a clock edge, the following all become zero: status, enables, thresholds, both levels and `irq`.
- R12: A flush empties its queue on the next edge, even when a push to that queue arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_push | input | 1 | Shift engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| tx_pop | input | 1 | Shift engine takes the next byte to send |
| tx_byte | output | 8 | Head of the transmit queue |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 16 | Configuration word written |
| cfg_rdata | output | 16 | Configuration word read back |
| data_wr | input | 1 | Software/DMA writes a byte to the transmit queue |
| data_wdata | input | 8 | Byte written to the transmit queue |
| data_rd | input | 1 | Software/DMA takes a byte from the receive queue |
| data_rdata | output | 8 | Head of the receive queue |
| sts_clr | input | 1 | Write-one-to-clear strobe for status |
| sts_wdata | input | 6 | Status bits to clear |
| ien_wr | input | 1 | Write strobe for the interrupt enable mask |
| ien_wdata | input | 6 | Interrupt enable mask |
| xfer_left | input | LEFT_W (16) | Bytes remaining in the current transfer |
| status | output | 6 | Event bits, positions as in R4 to R8 |
| irq | output | 1 | Interrupt request |
| rx_level | output | log2(DEPTH)+1 | Bytes held in the receive queue |
| tx_level | output | log2(DEPTH)+1 | Bytes held in the transmit queue |
| size_code | output | 2 | Queue depth code, 8 << code bytes |

## Verification
The assertions check the following on every cycle:
- the threshold comparisons turn into ready bits one edge later;
- overrun and underflow events raise their bits;
- the overrun bit holds until it is cleared;
- a flush empties its queue;
- the levels never exceed the depth;
- `irq` stays low while no status bit is set.

Only the bench scenarios can show:
- byte ordering through each queue, and that a byte dropped on overrun or on a full transmit write never appears;
- that a push and a read together on a full queue keep the new byte;
- the drain conditions against `xfer_left`, including the transmit case where the queue already covers the remaining length;
- the rule that a ready bit cleared while its condition holds comes straight back.

// File: rtl/i2cf_pkg.sv
// Package: constants shared by the I2C FIFO event block.
// Assumes a 16-bit configuration word with fixed field positions that the
// register decoder relies on.
package i2cf_pkg;
    localparam int ST_W       = 6;
    localparam int ST_RXRDY   = 0;
    localparam int ST_TXRDY   = 1;
    localparam int ST_RXDRN   = 2;
    localparam int ST_TXDRN   = 3;
    localparam int ST_RXOVR   = 4;
    localparam int ST_TXUDF   = 5;

    localparam int CFG_W      = 16;
    localparam int THR_W      = 6;
    localparam int CFG_RXCLR  = 14;
    localparam int CFG_RXTHR  = 8;
    localparam int CFG_TXCLR  = 6;
    localparam int CFG_TXTHR  = 0;

    typedef logic [ST_W-1:0] evt_vec_t;

    // Depth code: depth = 8 << code
    function automatic logic [1:0] depth_code(input int depth);
        return 2'($clog2(depth) - 3);
    endfunction
endpackage

// File: rtl/i2cf_byte_fifo.sv
// Module: synchronous byte queue with flush.
// Assumes DEPTH is a power of two; the head byte is read combinationally.
// A write on a full queue is accepted only when a read happens in the same
// cycle; flush wins over any write or read.
module i2cf_byte_fifo #(
    parameter  int DEPTH = 32,
    parameter  int DW    = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int LW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic [LW-1:0] level
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [LW-1:0] cnt;
    logic          full, empty, do_wr, do_rd;

    // Occupancy flags and accepted operations
    always_comb begin
        full  = (cnt == LW'(DEPTH));
        empty = (cnt == '0);
        do_rd = rd_en && !empty;
        do_wr = wr_en && (!full || do_rd);
    end

    // Storage array, no reset needed
    always_ff @(posedge clk) begin
        if (do_wr && !flush) mem[wp] <= wr_data;
    end

    // Pointers and count
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= wp + AW'(1);
            if (do_rd) rp <= rp + AW'(1);
            case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + LW'(1);
                2'b01:   cnt <= cnt - LW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assign rd_data = mem[rp];
    assign level   = cnt;
endmodule

// File: rtl/i2cf_evt_regs.sv
// Module: sticky event register with write-one-to-clear and enable mask.
// Assumes set requests take priority over a clear in the same cycle.
module i2cf_evt_regs #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic         clr_we,
    input  logic [N-1:0] clr_vec,
    input  logic         ien_we,
    input  logic [N-1:0] ien_vec,
    output logic [N-1:0] status,
    output logic         irq
);
    logic [N-1:0] ien_q;
    logic [N-1:0] clr_mask;

    // Clear mask active only on a clear strobe
    assign clr_mask = clr_we ? clr_vec : '0;

    // Status bits: clear by one, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_mask) | set_vec;
    end

    // Interrupt enable mask
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= '0;
        else if (ien_we) ien_q <= ien_vec;
    end

    assign irq = |(status & ien_q);
endmodule

// File: rtl/i2c_fifo_events.sv
// Module: paired receive/transmit byte queues with threshold, drain and error
// events for an I2C controller. Assumes DEPTH is a power of two from 8 to 64
// and LEFT_W is at least the threshold width. Conditions are evaluated from
// registered state and land in status one edge later.
module i2c_fifo_events
    import i2cf_pkg::*;
#(
    parameter  int DEPTH  = 32,
    parameter  int LEFT_W = 16,
    localparam int LW     = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_push,
    input  logic [7:0]        rx_byte,
    input  logic              tx_pop,
    output logic [7:0]        tx_byte,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              data_wr,
    input  logic [7:0]        data_wdata,
    input  logic              data_rd,
    output logic [7:0]        data_rdata,
    input  logic              sts_clr,
    input  logic [ST_W-1:0]   sts_wdata,
    input  logic              ien_wr,
    input  logic [ST_W-1:0]   ien_wdata,
    input  logic [LEFT_W-1:0] xfer_left,
    output logic [ST_W-1:0]   status,
    output logic              irq,
    output logic [LW-1:0]     rx_level,
    output logic [LW-1:0]     tx_level,
    output logic [1:0]        size_code
);
    localparam int CW = ((LW > THR_W) ? LW : THR_W) + 1;
    localparam logic [CFG_W-1:0] CLR_BITS =
        CFG_W'((1 << CFG_RXCLR) | (1 << CFG_TXCLR));

    logic [CFG_W-1:0] cfg_q;
    logic [THR_W-1:0] rx_thr, tx_thr;
    logic             rx_flush, tx_flush;
    logic             rx_rdy_c, tx_rdy_c, rx_drn_c, tx_drn_c;
    logic             rx_ovr_e, tx_udf_e;
    evt_vec_t         set_vec;

    // Configuration word; flush bits are strobes and are not kept
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_wr) cfg_q <= cfg_wdata & ~CLR_BITS;
    end

    assign rx_thr    = cfg_q[CFG_RXTHR +: THR_W];
    assign tx_thr    = cfg_q[CFG_TXTHR +: THR_W];
    assign rx_flush  = cfg_wr && cfg_wdata[CFG_RXCLR];
    assign tx_flush  = cfg_wr && cfg_wdata[CFG_TXCLR];
    assign cfg_rdata = cfg_q;
    assign size_code = depth_code(DEPTH);

    // Receive queue: bus side writes, register side reads
    i2cf_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_rxq (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (rx_flush),
        .wr_en   (rx_push),
        .wr_data (rx_byte),
        .rd_en   (data_rd),
        .rd_data (data_rdata),
        .level   (rx_level)
    );

    // Transmit queue: register side writes, bus side reads
    i2cf_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_txq (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (tx_flush),
        .wr_en   (data_wr),
        .wr_data (data_wdata),
        .rd_en   (tx_pop),
        .rd_data (tx_byte),
        .level   (tx_level)
    );

    // Threshold, drain and error conditions from current state
    always_comb begin
        rx_rdy_c = CW'(rx_level) >= (CW'(rx_thr) + CW'(1));
        tx_rdy_c = (CW'(DEPTH) - CW'(tx_level)) >= (CW'(tx_thr) + CW'(1));
        rx_drn_c = (rx_level != '0) && (xfer_left <= LEFT_W'(rx_thr));
        tx_drn_c = (xfer_left != '0) && (xfer_left <= LEFT_W'(tx_thr))
                   && (LEFT_W'(tx_level) < xfer_left);
        rx_ovr_e = rx_push && (rx_level == LW'(DEPTH)) && !data_rd;
        tx_udf_e = tx_pop && (tx_level == '0);
        set_vec           = '0;
        set_vec[ST_RXRDY] = rx_rdy_c;
        set_vec[ST_TXRDY] = tx_rdy_c;
        set_vec[ST_RXDRN] = rx_drn_c;
        set_vec[ST_TXDRN] = tx_drn_c;
        set_vec[ST_RXOVR] = rx_ovr_e;
        set_vec[ST_TXUDF] = tx_udf_e;
    end

    // Sticky status, clear-by-one and interrupt masking
    i2cf_evt_regs #(.N(ST_W)) u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_we  (sts_clr),
        .clr_vec (sts_wdata),
        .ien_we  (ien_wr),
        .ien_vec (ien_wdata),
        .status  (status),
        .irq     (irq)
    );
endmodule

// File: rtl/i2cf_chk.sv
// Module: property checker for i2c_fifo_events, attached by bind.
// Assumes the default status bit positions and configuration field layout.
module i2cf_chk #(
    parameter  int DEPTH = 32,
    localparam int LW    = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_push,
    input logic          tx_pop,
    input logic          data_rd,
    input logic          cfg_wr,
    input logic          rx_flush_bit,
    input logic          tx_flush_bit,
    input logic [5:0]    rx_thr_q,
    input logic [5:0]    tx_thr_q,
    input logic          sts_clr,
    input logic          ovr_clr_bit,
    input logic [5:0]    status,
    input logic          irq,
    input logic [LW-1:0] rx_level,
    input logic [LW-1:0] tx_level
);
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rx_level) <= DEPTH) && (int'(tx_level) <= DEPTH)); // R1

    AST_RXRDY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rx_level) > int'(rx_thr_q)) |=> status[0]); // R4

    AST_TXRDY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((DEPTH - int'(tx_level)) > int'(tx_thr_q)) |=> status[1]); // R5

    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_level == LW'(DEPTH) && !data_rd) |=> status[4]); // R7

    AST_UDF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop && tx_level == '0) |=> (status[5] && tx_level <= LW'(1))); // R8

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[4] && !(sts_clr && ovr_clr_bit)) |=> status[4]); // R9

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |-> !irq); // R10

    AST_RX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && rx_flush_bit) |=> (rx_level == '0)); // R12

    AST_TX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && tx_flush_bit) |=> (tx_level == '0)); // R12
endmodule

bind i2c_fifo_events i2cf_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_push      (rx_push),
    .tx_pop       (tx_pop),
    .data_rd      (data_rd),
    .cfg_wr       (cfg_wr),
    .rx_flush_bit (cfg_wdata[14]),
    .tx_flush_bit (cfg_wdata[6]),
    .rx_thr_q     (cfg_rdata[13:8]),
    .tx_thr_q     (cfg_rdata[5:0]),
    .sts_clr      (sts_clr),
    .ovr_clr_bit  (sts_wdata[4]),
    .status       (status),
    .irq          (irq),
    .rx_level     (rx_level),
    .tx_level     (tx_level)
);

// File: tb/sim_i2c_fifo_events.sv
// Bench: table of single operations with expected results, then directed
// corner cases. Inputs change on the falling edge, outputs are sampled there.
module sim_i2c_fifo_events;
    localparam logic [2:0] OP_CFG = 3'd0, OP_RXP = 3'd1, OP_RD  = 3'd2,
                           OP_TXW = 3'd3, OP_POP = 3'd4, OP_CLR = 3'd5,
                           OP_IEN = 3'd6, OP_LEFT = 3'd7;

    typedef struct packed {
        logic [2:0]  op;
        logic [15:0] arg;
        logic [5:0]  st;
        logic [5:0]  rxl;
        logic [5:0]  txl;
        logic        irq;
        logic        chkd;
        logic [7:0]  dat;
        logic [15:0] cfg;
    } vec_t;

    // Each row: one operation, one idle cycle, then all fields compared
    localparam vec_t VEC [16] = '{
        '{OP_CFG,  16'h0203, 6'h02, 6'd0, 6'd0, 1'b0, 1'b0, 8'h00, 16'h0203}, // R2 thresholds
        '{OP_RXP,  16'h00A1, 6'h02, 6'd1, 6'd0, 1'b0, 1'b0, 8'h00, 16'h0203},
        '{OP_RXP,  16'h00B2, 6'h02, 6'd2, 6'd0, 1'b0, 1'b0, 8'h00, 16'h0203}, // R4 below
        '{OP_RXP,  16'h00C3, 6'h03, 6'd3, 6'd0, 1'b0, 1'b0, 8'h00, 16'h0203}, // R4 reached
        '{OP_CLR,  16'h0001, 6'h03, 6'd3, 6'd0, 1'b0, 1'b0, 8'h00, 16'h0203}, // R9 re-set
        '{OP_RD,   16'h0000, 6'h03, 6'd2, 6'd0, 1'b0, 1'b1, 8'hA1, 16'h0203}, // R1 order
        '{OP_CLR,  16'h0001, 6'h02, 6'd2, 6'd0, 1'b0, 1'b0, 8'h00, 16'h0203}, // R9 cleared
        '{OP_TXW,  16'h0011, 6'h02, 6'd2, 6'd1, 1'b0, 1'b0, 8'h00, 16'h0203}, // R5
        '{OP_IEN,  16'h0002, 6'h02, 6'd2, 6'd1, 1'b1, 1'b0, 8'h00, 16'h0203}, // R10
        '{OP_POP,  16'h0000, 6'h02, 6'd2, 6'd0, 1'b1, 1'b1, 8'h11, 16'h0203},
        '{OP_POP,  16'h0000, 6'h22, 6'd2, 6'd0, 1'b1, 1'b0, 8'h00, 16'h0203}, // R8
        '{OP_IEN,  16'h0020, 6'h22, 6'd2, 6'd0, 1'b1, 1'b0, 8'h00, 16'h0203}, // R10
        '{OP_CLR,  16'h0022, 6'h02, 6'd2, 6'd0, 1'b0, 1'b0, 8'h00, 16'h0203}, // R9 R10
        '{OP_LEFT, 16'h0002, 6'h0E, 6'd2, 6'd0, 1'b0, 1'b0, 8'h00, 16'h0203}, // R6 both
        '{OP_CFG,  16'h4003, 6'h0E, 6'd0, 6'd0, 1'b0, 1'b0, 8'h00, 16'h0003}, // R12 R2
        '{OP_CLR,  16'h000C, 6'h0A, 6'd0, 6'd0, 1'b0, 1'b0, 8'h00, 16'h0003}  // R6 R9
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_push = 1'b0, tx_pop = 1'b0, cfg_wr = 1'b0, data_wr = 1'b0;
    logic        data_rd = 1'b0, sts_clr = 1'b0, ien_wr = 1'b0;
    logic [7:0]  rx_byte = '0, data_wdata = '0;
    logic [15:0] cfg_wdata = '0;
    logic [5:0]  sts_wdata = '0, ien_wdata = '0;
    logic [15:0] xfer_left = 16'd100;
    logic [7:0]  tx_byte, data_rdata;
    logic [15:0] cfg_rdata;
    logic [5:0]  status, rx_level, tx_level;
    logic        irq;
    logic [1:0]  size_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    i2c_fifo_events u0 (
        .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_byte(rx_byte),
        .tx_pop(tx_pop), .tx_byte(tx_byte), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .data_wr(data_wr),
        .data_wdata(data_wdata), .data_rd(data_rd), .data_rdata(data_rdata),
        .sts_clr(sts_clr), .sts_wdata(sts_wdata), .ien_wr(ien_wr),
        .ien_wdata(ien_wdata), .xfer_left(xfer_left), .status(status),
        .irq(irq), .rx_level(rx_level), .tx_level(tx_level),
        .size_code(size_code)
    );

    task automatic check(input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    // One operation for one cycle; returns the head byte seen before the edge
    task automatic do_op(input logic [2:0] op, input logic [15:0] arg,
                         output logic [7:0] seen);
        case (op)
            OP_CFG:  begin cfg_wr = 1'b1; cfg_wdata = arg; end
            OP_RXP:  begin rx_push = 1'b1; rx_byte = arg[7:0]; end
            OP_RD:   data_rd = 1'b1;
            OP_TXW:  begin data_wr = 1'b1; data_wdata = arg[7:0]; end
            OP_POP:  tx_pop = 1'b1;
            OP_CLR:  begin sts_clr = 1'b1; sts_wdata = arg[5:0]; end
            OP_IEN:  begin ien_wr = 1'b1; ien_wdata = arg[5:0]; end
            default: xfer_left = arg;
        endcase
        seen = (op == OP_POP) ? tx_byte : data_rdata;
        @(negedge clk);
        {cfg_wr, rx_push, data_rd, data_wr, tx_pop, sts_clr, ien_wr} = '0;
    endtask

    initial begin : main
        logic [7:0] seen;
        repeat (3) @(negedge clk);
        // R11 and R3: reset state
        check("R11 status in reset", 32'(status), 32'h0);
        check("R11 irq in reset", 32'(irq), 32'h0);
        check("R11 rx level in reset", 32'(rx_level), 32'h0);
        check("R11 tx level in reset", 32'(tx_level), 32'h0);
        check("R11 cfg in reset", 32'(cfg_rdata), 32'h0);
        check("R3 size code", 32'(size_code), 32'h2);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Table walk: R1 R2 R4 R5 R6 R8 R9 R10 R12
        for (int i = 0; i < 16; i++) begin
            do_op(VEC[i].op, VEC[i].arg, seen);
            idle();
            check($sformatf("R4/R5/R6/R9 vec %0d status", i), 32'(status), 32'(VEC[i].st));
            check($sformatf("R1 vec %0d rx level", i), 32'(rx_level), 32'(VEC[i].rxl));
            check($sformatf("R1 vec %0d tx level", i), 32'(tx_level), 32'(VEC[i].txl));
            check($sformatf("R10 vec %0d irq", i), 32'(irq), 32'(VEC[i].irq));
            check($sformatf("R2 vec %0d cfg", i), 32'(cfg_rdata), 32'(VEC[i].cfg));
            if (VEC[i].chkd)
                check($sformatf("R1 vec %0d head byte", i), 32'(seen), 32'(VEC[i].dat));
        end

        // R7: overrun drops the extra byte and is sticky
        do_op(OP_LEFT, 16'd100, seen);
        do_op(OP_CFG, 16'h0000, seen);
        do_op(OP_CLR, 16'h003F, seen);
        for (int i = 0; i < 32; i++) do_op(OP_RXP, 16'(8'h40 + i), seen);
        do_op(OP_RXP, 16'h00EE, seen);
        idle();
        check("R7 rx level at full", 32'(rx_level), 32'd32);
        check("R7 overrun bit", 32'(status[4]), 32'h1);
        for (int i = 0; i < 32; i++) begin
            do_op(OP_RD, 16'h0, seen);
            check("R7 R1 rx order after overrun", 32'(seen), 32'(8'h40 + i));
        end
        idle();
        check("R7 overrun still set", 32'(status[4]), 32'h1);
        do_op(OP_CLR, 16'h0010, seen);
        idle();
        check("R9 overrun cleared", 32'(status[4]), 32'h0);

        // R7: push and read together on a full queue are both accepted
        for (int i = 0; i < 32; i++) do_op(OP_RXP, 16'(8'h80 + i), seen);
        rx_push = 1'b1; rx_byte = 8'h5A; data_rd = 1'b1;
        @(negedge clk);
        rx_push = 1'b0; data_rd = 1'b0;
        idle();
        check("R7 full level with read+push", 32'(rx_level), 32'd32);
        check("R7 no overrun with read+push", 32'(status[4]), 32'h0);
        for (int i = 0; i < 32; i++) begin
            do_op(OP_RD, 16'h0, seen);
            check("R7 order after read+push", 32'(seen),
                  (i == 31) ? 32'h5A : 32'(8'h81 + i));
        end

        // R12: flush wins over a push in the same cycle
        do_op(OP_RXP, 16'h0033, seen);
        cfg_wr = 1'b1; cfg_wdata = 16'h4000; rx_push = 1'b1; rx_byte = 8'h44;
        @(negedge clk);
        cfg_wr = 1'b0; rx_push = 1'b0;
        idle();
        check("R12 rx flush beats push", 32'(rx_level), 32'd0);

        // R5 and R1: transmit space threshold and full write dropped
        do_op(OP_CFG, 16'h0003, seen);
        for (int i = 0; i < 29; i++) do_op(OP_TXW, 16'(8'h10 + i), seen);
        do_op(OP_CLR, 16'h0002, seen);
        idle();
        check("R5 tx ready off with free 3 thr 3", 32'(status[1]), 32'h0);
        for (int i = 29; i < 32; i++) do_op(OP_TXW, 16'(8'h10 + i), seen);
        do_op(OP_TXW, 16'h00FF, seen);
        idle();
        check("R1 tx write dropped when full", 32'(tx_level), 32'd32);
        do_op(OP_POP, 16'h0, seen);
        check("R1 tx head order", 32'(seen), 32'h10);
        do_op(OP_CFG, 16'h0043, seen);
        idle();
        check("R12 tx flush", 32'(tx_level), 32'd0);
        check("R2 tx clear bit reads zero", 32'(cfg_rdata), 32'h0003);
        check("R9 R5 tx ready back after flush", 32'(status[1]), 32'h1);

        // R6: transmit drain only while the queue is short of the remainder
        do_op(OP_CLR, 16'h003F, seen);
        do_op(OP_LEFT, 16'd2, seen);
        do_op(OP_TXW, 16'h0001, seen);
        do_op(OP_TXW, 16'h0002, seen);
        do_op(OP_CLR, 16'h0008, seen);
        idle();
        check("R6 no tx drain when level covers remainder", 32'(status[3]), 32'h0);
        do_op(OP_POP, 16'h0, seen);
        idle();
        check("R6 tx drain when level below remainder", 32'(status[3]), 32'h1);

        // R11: reset again mid-run
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R11 status after reset", 32'(status), 32'h0);
        check("R11 tx level after reset", 32'(tx_level), 32'h0);
        check("R11 cfg after reset", 32'(cfg_rdata), 32'h0);
        check("R11 irq after reset", 32'(irq), 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule